// File: doc/BRIEF.md
# Decrementing On-Delay Timer

This block is a single-channel on-delay timer for a ladder-logic style controller. A level enable input arms it, and a one-cycle timebase tick advances it. While the enable is low, the present value tracks the set value and the completion flag stays low. Once the enable rises, each tick lowers the present value by one. When the value reaches zero the completion flag rises, and both values then hold until the enable drops or a host writes the present value.

A mode input chooses how the count runs. In one mode the 16-bit value is four packed BCD digits, and each decrement borrows from digit to digit. In the other mode it is a plain binary count. A host write port can overwrite the present value while the timer runs. Writing a non-zero value after a timeout restarts the count without toggling the enable.

Top module: `ondelay_timer`

## Requirements
- R1: While rst_ni is low, pv_o is 0 and done_o is 0, and the stored enable history is low.
- R2: In any cycle where en_i is low, pv_o takes sv_i and done_o goes low at the next clock edge.
- R3: In the first cycle of en_i high (the rising edge), pv_o loads sv_i and no decrement happens. In later cycles with en_i high, pv_o changes only on cycles where tick_i is high.
- R4: done_o rises on the same edge at which pv_o reaches 0. pv_o never goes below 0, and done_o high always means pv_o is 0.
- R5: After timeout, pv_o and done_o hold their values for as long as en_i stays high and no write happens.
- R6: If en_i drops before timeout, pv_o returns to sv_i and done_o stays low.
- R7: With bcd_mode_i = 1, digit k sits in bits [4k+3:4k] and each decrement borrows across digits (0100 becomes 0099, 1000 becomes 0999). Set values range from 0000 to 9999.
- R8: With bcd_mode_i = 0, each decrement subtracts one in binary (0x0100 becomes 0x00FF). Set values range from 0x0000 to 0xFFFF.
- R9: If sv_i is 0, done_o is high after the first edge at which en_i is high.
- R10: While en_i is high, pv_we_i loads pv_wdata_i. The write takes priority over a tick and over the start edge. After the write, done_o is high exactly when pv_wdata_i is 0, and a non-zero write lets counting resume on later ticks.
- R11: A write while en_i is low has no effect, and pv_o still follows sv_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Timer enable level |
| tick_i | input | 1 | Timebase tick, one cycle wide |
| bcd_mode_i | input | 1 | 1 = packed BCD count, 0 = binary count |
| sv_i | input | 16 | Set value |
| pv_we_i | input | 1 | Present value write strobe |
| pv_wdata_i | input | 16 | Present value write data |
| pv_o | output | 16 | Present value |
| done_o | output | 1 | Completion flag |

## Verification
The assertions check several rules on every cycle: pv_o follows sv_i while the enable is low, the count holds on cycles without a tick, the count never wraps below zero, the completion flag implies a zero count, and the flag and count hold once the timer has timed out. Other behaviour can only be shown by the bench's scenarios. That covers the exact BCD borrow results such as 0100 to 0099 and 1000 to 0999, the binary step at 0x0100, a zero set value, a write racing a tick, a write while disabled, and a restart by a non-zero write after timeout. A seeded random run then compares every cycle against a reference model held in the bench.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DIGIT_W = 4;
  typedef enum logic {
    MODE_BIN = 1'b0,
    MODE_BCD = 1'b1
  } cnt_mode_e;
endpackage

// File: rtl/tmr_bcd_dec.sv
module tmr_bcd_dec
  import tmr_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  logic [DIGITS:0] borrow;
  assign borrow[0] = 1'b1;

  for (genvar k = 0; k < DIGITS; k++) begin : g_dig
    logic [DIGIT_W-1:0] d;
    assign d = val_i[k*DIGIT_W +: DIGIT_W];
    assign borrow[k+1] = borrow[k] & (d == '0);
    always_comb begin
      if (!borrow[k])      val_o[k*DIGIT_W +: DIGIT_W] = d;
      else if (d == '0)    val_o[k*DIGIT_W +: DIGIT_W] = DIGIT_W'(9);
      else                 val_o[k*DIGIT_W +: DIGIT_W] = d - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_bin_dec.sv
module tmr_bin_dec #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] val_o
);
  assign val_o = val_i - 1'b1;
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_q_o,
  output logic rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= 1'b0;
    else         en_q_o <= en_i;
  end
  assign rise_o = en_i & ~en_q_o;
endmodule

// File: rtl/ondelay_timer.sv
module ondelay_timer
  import tmr_pkg::*;
#(
  parameter int DIGITS = 4,
  localparam int W = DIGITS * DIGIT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         bcd_mode_i,
  input  logic [W-1:0] sv_i,
  input  logic         pv_we_i,
  input  logic [W-1:0] pv_wdata_i,
  output logic [W-1:0] pv_o,
  output logic         done_o
);
  logic         en_q, rise;
  logic [W-1:0] bcd_nxt, bin_nxt, dec_nxt;
  cnt_mode_e    mode;

  tmr_edge u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .en_q_o(en_q),
    .rise_o(rise)
  );

  tmr_bcd_dec #(.DIGITS(DIGITS)) u_bcd (.val_i(pv_o), .val_o(bcd_nxt));
  tmr_bin_dec #(.W(W))           u_bin (.val_i(pv_o), .val_o(bin_nxt));

  assign mode    = cnt_mode_e'(bcd_mode_i);
  assign dec_nxt = (mode == MODE_BCD) ? bcd_nxt : bin_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_o   <= '0;
      done_o <= 1'b0;
    end else if (!en_i) begin
      pv_o   <= sv_i;
      done_o <= 1'b0;
    end else if (pv_we_i) begin
      // write beats tick and start edge
      pv_o   <= pv_wdata_i;
      done_o <= (pv_wdata_i == '0);
    end else if (rise) begin
      pv_o   <= sv_i;
      done_o <= (sv_i == '0);
    end else if (done_o) begin
      pv_o   <= pv_o;
      done_o <= 1'b1;
    end else if (pv_o == '0) begin
      done_o <= 1'b1;
    end else if (tick_i) begin
      pv_o   <= dec_nxt;
      done_o <= (dec_nxt == '0);
    end
  end

  // R2
  en_low_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (pv_o == $past(sv_i)) && !done_o);
  // R3
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && !pv_we_i && !tick_i) |=> $stable(pv_o));
  // R4
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && en_q && !pv_we_i && pv_o == '0) |=> (pv_o == '0) && done_o);
  // R4
  done_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pv_o == '0));
  // R5
  timeout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_o && !pv_we_i) |=> done_o && $stable(pv_o));
endmodule

// File: tb/ondelay_timer_bench.sv
module ondelay_timer_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0, tick_i = 1'b0, bcd_mode_i = 1'b1, pv_we_i = 1'b0;
  logic [W-1:0] sv_i = '0, pv_wdata_i = '0;
  logic [W-1:0] pv_o;
  logic         done_o;

  int checks = 0, fails = 0;
  bit finished = 0;

  logic [W-1:0] m_pv = '0;
  logic         m_done = 1'b0, m_enq = 1'b0;

  always #2.5 clk = ~clk;

  ondelay_timer u_ondelay_timer (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick_i),
    .bcd_mode_i(bcd_mode_i), .sv_i(sv_i), .pv_we_i(pv_we_i),
    .pv_wdata_i(pv_wdata_i), .pv_o(pv_o), .done_o(done_o)
  );

  function automatic int bcd2int(logic [W-1:0] v);
    int r = 0;
    for (int k = 3; k >= 0; k--) r = r * 10 + int'(v[k*4 +: 4]);
    return r;
  endfunction

  function automatic logic [W-1:0] int2bcd(int n);
    logic [W-1:0] r = '0;
    for (int k = 0; k < 4; k++) begin
      r[k*4 +: 4] = 4'(n % 10);
      n = n / 10;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_dec(logic [W-1:0] v, logic bcd);
    if (bcd) return int2bcd(bcd2int(v) - 1);
    return v - 16'd1;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_step();
    logic [W-1:0] d;
    if (!en_i) begin m_pv = sv_i; m_done = 1'b0; end
    else if (pv_we_i) begin m_pv = pv_wdata_i; m_done = (pv_wdata_i == 0); end
    else if (!m_enq) begin m_pv = sv_i; m_done = (sv_i == 0); end
    else if (m_done) begin end
    else if (m_pv == 0) m_done = 1'b1;
    else if (tick_i) begin
      d = ref_dec(m_pv, bcd_mode_i);
      m_pv = d; m_done = (d == 0);
    end
    m_enq = en_i;
  endtask

  task automatic cyc(logic en, logic tk, logic we, logic [W-1:0] wd);
    en_i = en; tick_i = tk; pv_we_i = we; pv_wdata_i = wd;
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  function automatic logic [W-1:0] rnd_val(logic bcd);
    int n = ($urandom % 4 == 0) ? int'($urandom % 10000) : int'($urandom % 12);
    if (bcd) return int2bcd(n);
    return ($urandom % 4 == 0) ? W'($urandom) : W'(n);
  endfunction

  initial begin
    #(2.5ns * 2 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    chk("R1 pv", pv_o, 16'h0000);
    chk("R1 done", {15'b0, done_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // BCD borrow and start edge
    bcd_mode_i = 1'b1; sv_i = 16'h0100;
    cyc(0, 0, 0, 0);  chk("R2 pv follows sv", pv_o, 16'h0100);
    cyc(1, 1, 0, 0);  chk("R3 edge loads no dec", pv_o, 16'h0100);
    cyc(1, 1, 0, 0);  chk("R7 0100->0099", pv_o, 16'h0099);
    cyc(1, 0, 0, 0);  chk("R3 hold no tick", pv_o, 16'h0099);
    cyc(0, 0, 0, 0);  chk("R6 abort pv", pv_o, 16'h0100);
    chk("R6 abort done", {15'b0, done_o}, 16'h0);

    // timeout, hold, restart by write
    sv_i = 16'h0002;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);  chk("R3 tick dec", pv_o, 16'h0001);
    cyc(1, 1, 0, 0);  chk("R4 done rises", {15'b0, done_o}, 16'h1);
    chk("R4 pv zero", pv_o, 16'h0000);
    cyc(1, 1, 0, 0);  chk("R5 hold pv", pv_o, 16'h0000);
    chk("R5 hold done", {15'b0, done_o}, 16'h1);
    cyc(1, 1, 1, 16'h0003); chk("R10 write beats tick", pv_o, 16'h0003);
    chk("R10 done cleared", {15'b0, done_o}, 16'h0);
    cyc(1, 1, 0, 0);  chk("R10 resume", pv_o, 16'h0002);
    cyc(1, 0, 1, 16'h0000); chk("R10 zero write done", {15'b0, done_o}, 16'h1);

    // write while disabled
    cyc(0, 0, 1, 16'h1234); chk("R11 write ignored", pv_o, 16'h0002);

    // zero set value
    sv_i = 16'h0000;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);  chk("R9 zero sv done", {15'b0, done_o}, 16'h1);

    // binary mode
    bcd_mode_i = 1'b0; sv_i = 16'h0100;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);  chk("R8 0x0100->0x00FF", pv_o, 16'h00FF);
    sv_i = 16'hFFFF;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);  chk("R8 0xFFFF->0xFFFE", pv_o, 16'hFFFE);

    // BCD 1000 -> 0999
    bcd_mode_i = 1'b1; sv_i = 16'h1000;
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    cyc(1, 1, 0, 0);  chk("R7 1000->0999", pv_o, 16'h0999);

    // random run against model; mode and sv change only while disabled
    cyc(0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      logic en, tk, we;
      en = ($urandom % 16) != 0;
      if (!en) begin
        bcd_mode_i = 1'($urandom);
        sv_i = rnd_val(bcd_mode_i);
      end
      tk = ($urandom % 3) == 0;
      we = ($urandom % 25) == 0;
      cyc(en, tk, we, rnd_val(bcd_mode_i));
      chk("R4 model pv", pv_o, m_pv);
      chk("R5 model done", {15'b0, done_o}, {15'b0, m_done});
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule